// File: doc/BRIEF.md
# Pointer-Based Hard-Fault Line Repair

This block masks permanently failed bit cells in a 512-bit memory line. It does not compute a syndrome code. It keeps a short list of repair pointers for the line. Each pointer names one broken bit position and stores the value that position should hold. Each pointer also has a valid flag. When the line is read, the raw image from storage passes through the block, and every pointer in use forces its position to the stored value. When the line is written, every pointer in use copies the intended value of its position out of the write data. This means the correct bit survives even though the cell itself cannot hold it.

A failure report port adds a pointer when fault detection finds a newly broken cell. Pointers are handed out in ascending order. Once all of them are in use, further reports raise an uncorrectable flag and leave the existing list untouched. Two pointers may name the same position, for example when a cell that holds a pointer has itself failed and the position is re-covered. In that case the higher-numbered pointer decides the value. The storage array and the fault detection logic sit outside this block.

Top module: `ecp_line_repair`

## Requirements
- R1: After reset no pointer is in use. A read returns the raw line unchanged, and uncorr_o and rd_valid_o are low.
- R2: A read returns rd_raw_i, except that each position named by a pointer in use is replaced by that pointer's stored bit.
- R3: When several pointers in use name the same position, the read value comes from the highest-numbered one.
- R4: A write (wr_en_i) copies wr_data_i[index] into the stored bit of every pointer in use, on the same clock edge as the write.
- R5: A failure report (fail_en_i) with a free pointer claims the lowest-numbered free pointer. That pointer takes fail_idx_i (bit position 0..511) as its index and fail_val_i as its stored bit.
- R6: When a write and a failure report fall in the same cycle, the write is applied first. The new pointer's stored bit is then wr_data_i[fail_idx_i], and fail_val_i is ignored.
- R7: A failure report that arrives while all pointers are in use drives uncorr_o high for exactly the next cycle and changes no pointer.
- R8: rd_data_o and rd_valid_o are registered. They show the result of a read one cycle after rd_en_i. rd_valid_o is low in the cycle after a cycle without rd_en_i.
- R9: A read in the same cycle as a write uses the stored bits from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Line write strobe |
| wr_data_i | input | 512 | Intended line contents being written |
| rd_en_i | input | 1 | Line read strobe |
| rd_raw_i | input | 512 | Raw line image fetched from storage |
| rd_data_o | output | 512 | Repaired line, one cycle after rd_en_i |
| rd_valid_o | output | 1 | rd_data_o carries a read result |
| fail_en_i | input | 1 | New failed cell report |
| fail_idx_i | input | 9 | Bit position of the reported failure |
| fail_val_i | input | 1 | Correct value for the reported position |
| uncorr_o | output | 1 | Report rejected because every pointer is in use |

## Verification
Two pairs of events can fall in the same cycle. A line write can coincide with a failure report, and a line write can coincide with a read. The bench drives wr_en_i together with fail_en_i, with wr_data_i and fail_val_i set to opposite values at the reported position. It then reads that position and expects the write data's value. It also drives a read together with a write that flips covered bits, and expects the old stored values in that read and the new ones in the following read.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  localparam int unsigned DEF_LINE_W = 512;
  localparam int unsigned DEF_N_ENT  = 6;
endpackage

// File: rtl/ecp_entry_file.sv
module ecp_entry_file #(
  parameter int unsigned LINE_W = ecp_pkg::DEF_LINE_W,
  parameter int unsigned N_ENT  = ecp_pkg::DEF_N_ENT,
  localparam int unsigned IDX_W = $clog2(LINE_W),
  localparam int unsigned CNT_W = $clog2(N_ENT + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [LINE_W-1:0]            wr_data_i,
  input  logic                         fail_en_i,
  input  logic [IDX_W-1:0]             fail_idx_i,
  input  logic                         fail_val_i,
  output logic [N_ENT-1:0]             vld_o,
  output logic [N_ENT-1:0][IDX_W-1:0]  idx_o,
  output logic [N_ENT-1:0]             rep_o,
  output logic                         full_o
);

  logic [CNT_W-1:0]            cnt_q;
  logic [N_ENT-1:0]            vld_q;
  logic [N_ENT-1:0][IDX_W-1:0] idx_q;
  logic [N_ENT-1:0]            rep_q;
  logic                        alloc;
  logic                        new_rep;

  assign full_o  = (cnt_q == CNT_W'(N_ENT));
  assign alloc   = fail_en_i && !full_o;
  // write first: a same-cycle write defines the new entry's value
  assign new_rep = wr_en_i ? wr_data_i[fail_idx_i] : fail_val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (alloc) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        idx_q[g] <= '0;
        rep_q[g] <= 1'b0;
      end else if (alloc && cnt_q == CNT_W'(g)) begin
        vld_q[g] <= 1'b1;
        idx_q[g] <= fail_idx_i;
        rep_q[g] <= new_rep;
      end else if (vld_q[g] && wr_en_i) begin
        rep_q[g] <= wr_data_i[idx_q[g]];
      end
    end

    if (g > 0) begin : g_order
      // R5
      alloc_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_q[g] |-> vld_q[g-1]);
    end
  end

  assign vld_o = vld_q;
  assign idx_o = idx_q;
  assign rep_o = rep_q;

  // R7
  no_dealloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((vld_q & $past(vld_q)) == $past(vld_q)));

  // R7
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_en_i && full_o && !wr_en_i) |=> ($stable(idx_q) && $stable(rep_q)));

endmodule

// File: rtl/ecp_read_patch.sv
module ecp_read_patch #(
  parameter int unsigned LINE_W = ecp_pkg::DEF_LINE_W,
  parameter int unsigned N_ENT  = ecp_pkg::DEF_N_ENT,
  localparam int unsigned IDX_W = $clog2(LINE_W)
) (
  input  logic [LINE_W-1:0]            raw_i,
  input  logic [N_ENT-1:0]             vld_i,
  input  logic [N_ENT-1:0][IDX_W-1:0]  idx_i,
  input  logic [N_ENT-1:0]             rep_i,
  output logic [LINE_W-1:0]            data_o
);

  // ascending scan: higher entry overrides lower on same index
  always_comb begin
    data_o = raw_i;
    for (int i = 0; i < N_ENT; i++) begin
      if (vld_i[i]) data_o[idx_i[i]] = rep_i[i];
    end
  end

  // R1
  always_comb begin
    if (vld_i == '0) begin
      empty_pass_chk: assert (data_o == raw_i);
    end
  end

endmodule

// File: rtl/ecp_line_repair.sv
module ecp_line_repair #(
  parameter int unsigned LINE_W = ecp_pkg::DEF_LINE_W,
  parameter int unsigned N_ENT  = ecp_pkg::DEF_N_ENT,
  localparam int unsigned IDX_W = $clog2(LINE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [LINE_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [LINE_W-1:0] rd_raw_i,
  output logic [LINE_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic              fail_en_i,
  input  logic [IDX_W-1:0]  fail_idx_i,
  input  logic              fail_val_i,
  output logic              uncorr_o
);

  logic [N_ENT-1:0]            vld;
  logic [N_ENT-1:0][IDX_W-1:0] idx;
  logic [N_ENT-1:0]            rep;
  logic                        full;
  logic [LINE_W-1:0]           patched;
  logic [LINE_W-1:0]           rd_data_q;
  logic                        rd_vld_q;
  logic                        uncorr_q;

  ecp_entry_file #(.LINE_W(LINE_W), .N_ENT(N_ENT)) u_ent (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .fail_en_i  (fail_en_i),
    .fail_idx_i (fail_idx_i),
    .fail_val_i (fail_val_i),
    .vld_o      (vld),
    .idx_o      (idx),
    .rep_o      (rep),
    .full_o     (full)
  );

  ecp_read_patch #(.LINE_W(LINE_W), .N_ENT(N_ENT)) u_patch (
    .raw_i  (rd_raw_i),
    .vld_i  (vld),
    .idx_i  (idx),
    .rep_i  (rep),
    .data_o (patched)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q <= '0;
      rd_vld_q  <= 1'b0;
      uncorr_q  <= 1'b0;
    end else begin
      rd_vld_q <= rd_en_i;
      uncorr_q <= fail_en_i && full;
      if (rd_en_i) rd_data_q <= patched;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_vld_q;
  assign uncorr_o   = uncorr_q;

  // R7
  uncorr_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_en_i && vld[N_ENT-1]) |=> uncorr_o);

  // R7
  uncorr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fail_en_i |=> !uncorr_o);

  // R8
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  // R8
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

endmodule

// File: tb/tb_ecp_line_repair.sv
module tb_ecp_line_repair;
  localparam int LW = 512;
  localparam int NE = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [LW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [LW-1:0] rd_raw = '0;
  logic [LW-1:0] rd_data;
  logic          rd_valid;
  logic          fail_en = 1'b0;
  logic [8:0]    fail_idx = '0;
  logic          fail_val = 1'b0;
  logic          uncorr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int         m_cnt = 0;
  logic [8:0] m_idx [NE];
  logic       m_rep [NE];

  always #5 clk = ~clk;

  ecp_line_repair dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_raw_i(rd_raw),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .fail_en_i(fail_en), .fail_idx_i(fail_idx), .fail_val_i(fail_val),
    .uncorr_o(uncorr)
  );

  function automatic logic [LW-1:0] model_read(logic [LW-1:0] raw);
    logic [LW-1:0] r = raw;
    for (int i = 0; i < m_cnt; i++) r[m_idx[i]] = m_rep[i];
    return r;
  endfunction

  task automatic chk_line(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic model_write(logic [LW-1:0] d);
    for (int i = 0; i < m_cnt; i++) m_rep[i] = d[m_idx[i]];
  endtask

  task automatic do_read(string req, logic [LW-1:0] raw);
    logic [LW-1:0] exp = model_read(raw);
    @(negedge clk);
    rd_en = 1'b1; rd_raw = raw;
    @(negedge clk);
    rd_en = 1'b0;
    chk_bit({req, " rd_valid"}, rd_valid, 1'b1);
    chk_line(req, rd_data, exp);
  endtask

  task automatic do_write(logic [LW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(d);
  endtask

  task automatic do_fail(string req, logic [8:0] idx, logic val,
                         bit with_wr, logic [LW-1:0] d);
    bit exp_unc;
    @(negedge clk);
    fail_en = 1'b1; fail_idx = idx; fail_val = val;
    wr_en = with_wr; wr_data = d;
    @(negedge clk);
    fail_en = 1'b0; wr_en = 1'b0;
    if (with_wr) model_write(d);
    exp_unc = (m_cnt == NE);
    if (!exp_unc) begin
      m_idx[m_cnt] = idx;
      m_rep[m_cnt] = with_wr ? d[idx] : val;
      m_cnt++;
    end
    chk_bit({req, " uncorr"}, uncorr, exp_unc);
  endtask

  task automatic t_reset;
    chk_bit("R1 rd_valid after reset", rd_valid, 1'b0);
    chk_bit("R1 uncorr after reset", uncorr, 1'b0);
    do_read("R1 raw passthrough", {16{32'hA5C3_0F96}});
    @(negedge clk);
    chk_bit("R8 idle rd_valid", rd_valid, 1'b0);
  endtask

  task automatic t_single;
    do_fail("R5 alloc idx5", 9'd5, 1'b1, 1'b0, '0);
    do_read("R2 single override", '0);
    do_read("R2 single override ones", '1);
  endtask

  task automatic t_write_capture;
    logic [LW-1:0] d = '1;
    d[5] = 1'b0;
    do_write(d);
    do_read("R4 write capture", '1);
  endtask

  task automatic t_dup;
    do_fail("R5 alloc dup idx5", 9'd5, 1'b1, 1'b0, '0);
    do_read("R3 highest entry wins", '0);
  endtask

  task automatic t_edges;
    do_fail("R5 alloc idx0", 9'd0, 1'b1, 1'b0, '0);
    do_fail("R5 alloc idx511", 9'd511, 1'b0, 1'b0, '0);
    do_read("R2 edge positions", {16{32'h5A5A_F00F}});
    do_read("R2 edge positions ones", '1);
  endtask

  task automatic t_same_cycle;
    logic [LW-1:0] d = {16{32'h0000_0000}};
    d[100] = 1'b1; d[5] = 1'b1; d[511] = 1'b1;
    do_fail("R6 write plus report", 9'd100, 1'b0, 1'b1, d);
    do_read("R6 new entry takes write bit", '0);
  endtask

  task automatic t_read_write;
    logic [LW-1:0] d = '0;
    logic [LW-1:0] exp_old = model_read('1);
    @(negedge clk);
    rd_en = 1'b1; rd_raw = '1; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk_line("R9 read sees pre-write bits", rd_data, exp_old);
    model_write(d);
    do_read("R9 following read sees new bits", '1);
  endtask

  task automatic t_full;
    logic [LW-1:0] raw = '0;
    do_fail("R5 alloc last entry", 9'd200, 1'b1, 1'b0, '0);
    do_fail("R7 report when full", 9'd300, 1'b1, 1'b0, '0);
    @(negedge clk);
    chk_bit("R7 uncorr single cycle", uncorr, 1'b0);
    do_read("R7 full report leaves entries", raw);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_write_capture();
    t_dup();
    t_edges();
    t_same_cycle();
    t_read_write();
    t_full();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule